// File: doc/BRIEF.md
# CAN Mailbox Transmit Arbiter

This block is the transmit half of a 32-entry CAN mailbox bank. Software raises a transmit request for a mailbox by writing a one to its bit in a write-one-to-set strobe. The block keeps the request vector. It looks at every mailbox that is switched on, set to the transmit direction and requesting. It then names the one to hand to the CAN bit engine next. Each mailbox carries a 6-bit priority. The winner is the mailbox with the largest priority value, and a tie goes to the highest-numbered contender.

The bit engine attaches through a start/done handshake. While the arbiter is idle and holds a valid winner, it latches that index on the next clock and raises `tx_active`. The index stays frozen until the engine returns `tx_done` or `tx_err`. On success the block does three things: it sets the mailbox's acknowledge bit, it drops the request, and it can raise the mailbox interrupt. On failure the request is kept and the mailbox competes again from the next idle cycle. Software clears acknowledge bits by writing ones.

Top module: `can_txmb_arb`

## Requirements
- R1: After reset, `req_vec` and `ack_vec` are all zero, `tx_active` is 0, `sel_valid` is 0 and `mbx_irq` is 0.
- R2: On a clock where `req_set_wr` is 1, every bit that is 1 in `req_set_data` sets the matching bit of `req_vec`. Bits that are 0 leave `req_vec` unchanged.
- R3: A mailbox can be selected only when its `mbx_en` bit is 1, its `mbx_dir` bit is 0 (0 = transmit, 1 = receive) and its `req_vec` bit is 1. A requesting mailbox with `mbx_dir` 1 or `mbx_en` 0 is never selected.
- R4: Mailbox i's priority is `mbx_prio[6*i+5:6*i]`. Among the eligible mailboxes, the one with the largest priority value is selected.
- R5: When several eligible mailboxes share the largest priority, the highest-numbered one is selected.
- R6: While idle, `sel_valid` and `sel_index` follow the current eligible set with no register in between. A request written on one clock edge shows as a selection right after that same edge.
- R7: When idle with `sel_valid` 1, the next clock raises `tx_active` with `tx_index` equal to the selected index. While `tx_active` is 1, `tx_index` and `sel_index` stay frozen even if a higher-priority request appears.
- R8: `tx_done` while `tx_active` sets `ack_vec[tx_index]`, clears `req_vec[tx_index]` and drops `tx_active` on that clock. `tx_done` takes precedence over `tx_err`.
- R9: `tx_err` (without `tx_done`) while `tx_active` drops `tx_active` and leaves the request set, so the mailbox re-enters arbitration.
- R10: On a clock where `ack_clr_wr` is 1, every bit that is 1 in `ack_clr_data` clears the matching bit of `ack_vec`. A completion on the same clock sets its bit regardless.
- R11: `mbx_irq` is 1 exactly when some mailbox has both its `ack_vec` bit and its `mbx_int_en` bit at 1.
- R12: If a request set and a completion of the same mailbox fall on one clock, the request remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbx_en | input | 32 | Per-mailbox enable |
| mbx_dir | input | 32 | Per-mailbox direction, 1 = receive |
| mbx_int_en | input | 32 | Per-mailbox interrupt mask |
| mbx_prio | input | 192 | Six priority bits per mailbox, mailbox i at bits 6i+5:6i |
| req_set_wr | input | 1 | Request-set strobe |
| req_set_data | input | 32 | Request bits to set |
| ack_clr_wr | input | 1 | Acknowledge-clear strobe |
| ack_clr_data | input | 32 | Acknowledge bits to clear |
| tx_done | input | 1 | Bit engine reports frame sent |
| tx_err | input | 1 | Bit engine reports frame failed |
| tx_active | output | 1 | Frame handed to the bit engine |
| tx_index | output | 5 | Mailbox being sent |
| sel_valid | output | 1 | A mailbox is selected |
| sel_index | output | 5 | Selected mailbox |
| req_vec | output | 32 | Pending transmit requests |
| ack_vec | output | 32 | Transmit acknowledge bits |
| mbx_irq | output | 1 | Global mailbox interrupt flag |

## Verification
The bench targets priority ties. A design that breaks ties toward the lowest index would send mailbox 3 before 14. It also targets receive-direction mailboxes that hold requests; a design that missed the direction test would start a frame for one of them. A higher-priority request arrives during a frame, which a design without the freeze would answer by changing `tx_index` mid-frame. Failed frames must keep their request, or the mailbox would silently lose its frame. A request re-set on the clock its frame completes must survive, or a back-to-back resend would vanish. A randomized phase mixes all of these with clears, mask and configuration changes.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
   localparam int MBX_N  = 32;
   localparam int PRIO_W = 6;
   localparam int IDX_W  = $clog2(MBX_N);

   typedef struct packed {
      logic              vld;
      logic [PRIO_W-1:0] prio;
      logic [IDX_W-1:0]  idx;
   } cand_t;

   typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} tx_st_e;

   // hi always covers higher mailbox numbers than lo; equal priority favours hi
   function automatic cand_t cand_pick(cand_t lo, cand_t hi);
      if (!hi.vld) return lo;
      if (!lo.vld) return hi;
      if (hi.prio >= lo.prio) return hi;
      return lo;
   endfunction
endpackage

// File: rtl/can_txmb_tree.sv
module can_txmb_tree
   import can_txmb_pkg::*;
#(
   parameter int NUM_MBX = 32,
   parameter int PW      = 6,
   parameter int IW      = $clog2(NUM_MBX)
) (
   input  logic [NUM_MBX-1:0]    elig,
   input  logic [NUM_MBX*PW-1:0] prio_flat,
   output logic                  win_vld,
   output logic [IW-1:0]         win_idx
);
   localparam int NODES = 2 * NUM_MBX - 1;

   cand_t node [NODES];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_MBX; gi++) begin : g_leaf
         assign node[NUM_MBX-1+gi] = '{vld: elig[gi], prio: prio_flat[gi*PW +: PW], idx: IW'(gi)};
      end
      for (gi = 0; gi < NUM_MBX - 1; gi++) begin : g_node
         assign node[gi] = cand_pick(node[2*gi+1], node[2*gi+2]);
      end
   endgenerate

   assign win_vld = node[0].vld;
   assign win_idx = node[0].idx;
endmodule

// File: rtl/can_txmb_regs.sv
module can_txmb_regs #(
   parameter int NUM_MBX = 32,
   parameter int IW      = $clog2(NUM_MBX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_wr,
   input  logic [NUM_MBX-1:0] set_data,
   input  logic               clr_wr,
   input  logic [NUM_MBX-1:0] clr_data,
   input  logic               done_pulse,
   input  logic [IW-1:0]      done_idx,
   output logic [NUM_MBX-1:0] req_q,
   output logic [NUM_MBX-1:0] ack_q
);
   logic [NUM_MBX-1:0] done_mask;
   logic [NUM_MBX-1:0] set_mask;
   logic [NUM_MBX-1:0] clr_mask;

   genvar gb;
   generate
      for (gb = 0; gb < NUM_MBX; gb++) begin : g_dec
         assign done_mask[gb] = done_pulse && (done_idx == IW'(gb));
      end
   endgenerate

   assign set_mask = set_wr ? set_data : '0;
   assign clr_mask = clr_wr ? clr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         ack_q <= '0;
      end else begin
         req_q <= (req_q & ~done_mask) | set_mask;
         ack_q <= (ack_q & ~clr_mask) | done_mask;
      end
   end
endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb
   import can_txmb_pkg::*;
#(
   parameter int NUM_MBX = 32,
   parameter int PRIO_W  = 6,
   parameter int IDX_W   = $clog2(NUM_MBX)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_MBX-1:0]        mbx_en,
   input  logic [NUM_MBX-1:0]        mbx_dir,
   input  logic [NUM_MBX-1:0]        mbx_int_en,
   input  logic [NUM_MBX*PRIO_W-1:0] mbx_prio,
   input  logic                      req_set_wr,
   input  logic [NUM_MBX-1:0]        req_set_data,
   input  logic                      ack_clr_wr,
   input  logic [NUM_MBX-1:0]        ack_clr_data,
   input  logic                      tx_done,
   input  logic                      tx_err,
   output logic                      tx_active,
   output logic [IDX_W-1:0]          tx_index,
   output logic                      sel_valid,
   output logic [IDX_W-1:0]          sel_index,
   output logic [NUM_MBX-1:0]        req_vec,
   output logic [NUM_MBX-1:0]        ack_vec,
   output logic                      mbx_irq
);
   generate
      if (NUM_MBX != (1 << IDX_W)) begin : g_bad_n
         $error("NUM_MBX must be a power of two matching IDX_W");
      end
      if (NUM_MBX != MBX_N || PRIO_W != can_txmb_pkg::PRIO_W) begin : g_bad_pkg
         $error("parameters must match the shared candidate type");
      end
   endgenerate

   tx_st_e             st_q;
   logic [IDX_W-1:0]   cur_idx_q;
   logic [NUM_MBX-1:0] req_q;
   logic [NUM_MBX-1:0] ack_q;
   logic [NUM_MBX-1:0] elig;
   logic               win_vld;
   logic [IDX_W-1:0]   win_idx;
   logic               done_pulse;

   assign elig       = mbx_en & ~mbx_dir & req_q;
   assign done_pulse = (st_q == ST_SEND) && tx_done;

   can_txmb_regs #(.NUM_MBX(NUM_MBX), .IW(IDX_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_wr     (req_set_wr),
      .set_data   (req_set_data),
      .clr_wr     (ack_clr_wr),
      .clr_data   (ack_clr_data),
      .done_pulse (done_pulse),
      .done_idx   (cur_idx_q),
      .req_q      (req_q),
      .ack_q      (ack_q)
   );

   can_txmb_tree #(.NUM_MBX(NUM_MBX), .PW(PRIO_W), .IW(IDX_W)) u_tree (
      .elig      (elig),
      .prio_flat (mbx_prio),
      .win_vld   (win_vld),
      .win_idx   (win_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cur_idx_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (win_vld) begin
               st_q      <= ST_SEND;
               cur_idx_q <= win_idx;
            end
            ST_SEND: if (tx_done || tx_err) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign tx_active = (st_q == ST_SEND);
   assign tx_index  = cur_idx_q;
   assign sel_valid = tx_active ? 1'b1 : win_vld;
   assign sel_index = tx_active ? cur_idx_q : win_idx;
   assign req_vec   = req_q;
   assign ack_vec   = ack_q;
   assign mbx_irq   = |(ack_q & mbx_int_en);
endmodule

// File: rtl/can_txmb_arb_chk.sv
module can_txmb_arb_chk #(
   parameter int NUM_MBX = 32,
   parameter int IDX_W   = $clog2(NUM_MBX)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_MBX-1:0] mbx_en,
   input logic [NUM_MBX-1:0] mbx_dir,
   input logic               req_set_wr,
   input logic [NUM_MBX-1:0] req_set_data,
   input logic               tx_done,
   input logic               tx_err,
   input logic               tx_active,
   input logic [IDX_W-1:0]   tx_index,
   input logic               sel_valid,
   input logic [IDX_W-1:0]   sel_index,
   input logic [NUM_MBX-1:0] req_vec,
   input logic [NUM_MBX-1:0] ack_vec
);
   a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      req_set_wr |=> ((req_vec & $past(req_set_data)) == $past(req_set_data)));

   a_r3_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !tx_active) |-> (mbx_en[sel_index] && !mbx_dir[sel_index] && req_vec[sel_index]));

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && !tx_done && !tx_err) |=> (tx_active && $stable(tx_index)));

   a_r8_done_acks: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && tx_done) |=> (ack_vec[$past(tx_index)] && !tx_active));

   a_r9_err_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && tx_err && !tx_done) |=> (req_vec[$past(tx_index)] && !tx_active));
endmodule

bind can_txmb_arb can_txmb_arb_chk #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .mbx_en       (mbx_en),
   .mbx_dir      (mbx_dir),
   .req_set_wr   (req_set_wr),
   .req_set_data (req_set_data),
   .tx_done      (tx_done),
   .tx_err       (tx_err),
   .tx_active    (tx_active),
   .tx_index     (tx_index),
   .sel_valid    (sel_valid),
   .sel_index    (sel_index),
   .req_vec      (req_vec),
   .ack_vec      (ack_vec)
);

// File: tb/can_txmb_arb_tb.sv
`timescale 1ns/1ps
module can_txmb_arb_tb_top;
   localparam int CLK_P = 10;
   localparam int N     = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  mbx_en = '0, mbx_dir = '0, mbx_int_en = '0;
   logic [N*6-1:0] mbx_prio = '0;
   logic          stim_wr = 1'b0;
   logic [N-1:0]  stim_data = '0;
   logic          resp_wr = 1'b0;
   logic [N-1:0]  resp_data = '0;
   logic          req_set_wr;
   logic [N-1:0]  req_set_data;
   logic          ack_clr_wr = 1'b0;
   logic [N-1:0]  ack_clr_data = '0;
   logic          tx_done = 1'b0, tx_err = 1'b0;
   logic          tx_active, sel_valid, mbx_irq;
   logic [4:0]    tx_index, sel_index;
   logic [N-1:0]  req_vec, ack_vec;

   assign req_set_wr   = stim_wr | resp_wr;
   assign req_set_data = (stim_wr ? stim_data : '0) | (resp_wr ? resp_data : '0);

   always #(CLK_P/2) clk = ~clk;

   can_txmb_arb dut_i (
      .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en), .mbx_dir(mbx_dir),
      .mbx_int_en(mbx_int_en), .mbx_prio(mbx_prio),
      .req_set_wr(req_set_wr), .req_set_data(req_set_data),
      .ack_clr_wr(ack_clr_wr), .ack_clr_data(ack_clr_data),
      .tx_done(tx_done), .tx_err(tx_err),
      .tx_active(tx_active), .tx_index(tx_index),
      .sel_valid(sel_valid), .sel_index(sel_index),
      .req_vec(req_vec), .ack_vec(ack_vec), .mbx_irq(mbx_irq)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [N-1:0] m_req = '0, m_ack = '0;
   bit           m_busy = 0;
   int           m_idx = 0;

   function automatic int ref_winner();
      int best = -1;
      int bp = -1;
      for (int i = 0; i < N; i++) begin
         if (mbx_en[i] && !mbx_dir[i] && m_req[i]) begin
            if (int'(mbx_prio[i*6 +: 6]) >= bp) begin
               bp = int'(mbx_prio[i*6 +: 6]);
               best = i;
            end
         end
      end
      return best;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = '0; m_ack = '0; m_busy = 0; m_idx = 0;
      end else begin
         int w;
         logic [N-1:0] dm;
         w = ref_winner();
         dm = '0;
         if (m_busy) begin
            if (tx_done) begin dm[m_idx] = 1'b1; m_busy = 0; end
            else if (tx_err) m_busy = 0;
         end else if (w >= 0) begin
            m_busy = 1; m_idx = w;
         end
         m_ack = (m_ack & ~(ack_clr_wr ? ack_clr_data : '0)) | dm;
         m_req = (m_req & ~dm) | (req_set_wr ? req_set_data : '0);
      end
   end

   // compare every cycle, one step after the edge
   bit cmp_on = 0;
   always @(posedge clk) begin
      #1;
      if (cmp_on) begin
         int w;
         w = ref_winner();
         chk("R2/R8/R12 req_vec", req_vec, m_req);
         chk("R8/R10 ack_vec", ack_vec, m_ack);
         chk("R11 mbx_irq", {31'b0, mbx_irq}, {31'b0, |(m_ack & mbx_int_en)});
         chk("R7 tx_active", {31'b0, tx_active}, {31'b0, m_busy});
         if (m_busy) begin
            chk("R7 tx_index", {27'b0, tx_index}, m_idx);
            chk("R7 sel_index frozen", {27'b0, sel_index}, m_idx);
            chk("R7 sel_valid", {31'b0, sel_valid}, 32'd1);
         end else begin
            chk("R3/R6 sel_valid", {31'b0, sel_valid}, {31'b0, w >= 0});
            if (w >= 0) chk("R4/R5 sel_index", {27'b0, sel_index}, w);
         end
      end
   end

   // ---------------- bit engine model ----------------
   bit resp_en = 0, fail_next = 0, resend = 0;
   int lat = 2, cnt = 0;
   always @(negedge clk) begin
      tx_done = 0; tx_err = 0; resp_wr = 0; resp_data = '0;
      if (tx_active && resp_en) begin
         cnt++;
         if (cnt >= lat) begin
            cnt = 0;
            if (fail_next) begin tx_err = 1; fail_next = 0; end
            else begin
               tx_done = 1;
               if (resend) begin resp_wr = 1; resp_data = '0; resp_data[tx_index] = 1'b1; end
            end
         end
      end else cnt = 0;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic set_req(input logic [N-1:0] bits);
      @(negedge clk); stim_wr = 1; stim_data = bits;
      @(negedge clk); stim_wr = 0; stim_data = '0;
   endtask

   task automatic clr_ack(input logic [N-1:0] bits);
      @(negedge clk); ack_clr_wr = 1; ack_clr_data = bits;
      @(negedge clk); ack_clr_wr = 0; ack_clr_data = '0;
   endtask

   task automatic drain();
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         if (!tx_active && ((req_vec & mbx_en & ~mbx_dir) == '0)) break;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(posedge clk); #1;
      chk("R1 req_vec", req_vec, '0);
      chk("R1 ack_vec", ack_vec, '0);
      chk("R1 idle", {29'b0, tx_active, sel_valid, mbx_irq}, '0);
      cmp_on = 1;

      // R3: receive-direction and disabled mailboxes are ignored
      @(negedge clk);
      mbx_en = 32'hFFFF_FFFF; mbx_en[25] = 1'b0;
      mbx_dir = 32'hFFFF_0000;
      for (int i = 0; i < N; i++) mbx_prio[i*6 +: 6] = 6'((i * 7) % 64);
      set_req(32'h0210_0000);        // mailbox 20 (rx) and 25 (disabled)
      @(posedge clk); #1;
      chk("R3 no selection", {31'b0, sel_valid}, 32'd0);
      chk("R3 not started", {31'b0, tx_active}, 32'd0);

      // R4 + R6: highest priority wins, visible right after the write edge
      @(negedge clk);
      mbx_prio[2*6 +: 6] = 6'd40; mbx_prio[10*6 +: 6] = 6'd20; mbx_prio[5*6 +: 6] = 6'd3;
      stim_wr = 1; stim_data = 32'h0000_0424;
      @(posedge clk); #1;
      chk("R6 same-edge valid", {31'b0, sel_valid}, 32'd1);
      chk("R4 highest prio", {27'b0, sel_index}, 32'd2);
      @(negedge clk); stim_wr = 0; stim_data = '0;
      @(posedge clk); #1;
      chk("R7 started", {31'b0, tx_active}, 32'd1);
      chk("R7 tx_index", {27'b0, tx_index}, 32'd2);
      // R7: higher priority arrives mid-frame
      @(negedge clk); mbx_prio[12*6 +: 6] = 6'd63;
      set_req(32'h0000_1000);
      @(posedge clk); #1;
      chk("R7 still frozen", {27'b0, tx_index}, 32'd2);
      mbx_int_en = 32'h0000_0004;
      resp_en = 1;
      drain();
      @(posedge clk); #1;
      chk("R8 acks", ack_vec & 32'h0000_1424, 32'h0000_1424);
      chk("R11 irq set", {31'b0, mbx_irq}, 32'd1);
      clr_ack(32'h0000_0004);
      @(posedge clk); #1;
      chk("R10 cleared", ack_vec & 32'h0000_1424, 32'h0000_1420);
      chk("R11 irq low", {31'b0, mbx_irq}, 32'd0);
      clr_ack(32'hFFFF_FFFF);

      // R5: ties pick the highest number
      resp_en = 0;
      @(negedge clk);
      for (int i = 0; i < N; i++) mbx_prio[i*6 +: 6] = 6'd5;
      set_req(32'h0000_4208);
      @(posedge clk); #1;
      chk("R5 tie", {27'b0, sel_index}, 32'd14);

      // R9: failure keeps the request
      fail_next = 1; resp_en = 1;
      drain();
      @(posedge clk); #1;
      chk("R9 all sent after retry", req_vec & 32'h0000_4208, 32'd0);

      // R12: resend on completion edge
      resend = 1;
      set_req(32'h0000_0080);
      for (int k = 0; k < 50; k++) begin
         @(posedge clk); #1;
         if (ack_vec[7]) break;
      end
      resend = 0;
      chk("R12 req kept", {31'b0, req_vec[7]}, 32'd1);
      drain();

      // randomized mix
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         stim_wr = ($urandom % 4 == 0);
         stim_data = $urandom & $urandom;
         ack_clr_wr = ($urandom % 8 == 0);
         ack_clr_data = $urandom;
         if ($urandom % 50 == 0) mbx_en = $urandom | $urandom;
         if ($urandom % 60 == 0) mbx_dir = $urandom & $urandom;
         if ($urandom % 70 == 0) mbx_int_en = $urandom;
         if ($urandom % 40 == 0) begin
            bit flat;
            flat = ($urandom % 3 == 0);
            for (int i = 0; i < N; i++) mbx_prio[i*6 +: 6] = flat ? 6'd9 : 6'($urandom % 64);
         end
         if ($urandom % 6 == 0) fail_next = 1;
         resend = ($urandom % 5 == 0);
         lat = 1 + int'($urandom % 4);
      end
      @(negedge clk); stim_wr = 0; ack_clr_wr = 0; resend = 0;
      repeat (4) @(negedge clk);
      cmp_on = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule